// File: doc/BRIEF.md
# Serial Interrupt Host Frame Controller

This block is the host end of a shared, open-drain serial interrupt line. It opens each interrupt cycle with a start pulse, either on its own or by taking over a one-clock low pulse from a slave agent. It then counts sixteen three-clock data slots and captures the line level in the sample clock of each slot. It closes the cycle with a stop pulse whose length tells every agent which mode the next cycle runs in. The captured levels are published as a 16-bit vector once per cycle.

The line itself is outside the block. The block reports what it wants on the line through separate drive-low, drive-high and output-enable signals, and it reads the resolved line level back on `lineIn`. A 2-bit mode input picks what the next stop pulse announces. The choices are quiet operation, where slaves may request cycles; continuous running, where the host restarts after every stop; and continuous hold, where the line stays idle until the mode input asks for something else.

Top module: `serirq_host_ctrl`

## Requirements
- R1: While `rstN` is low, `driveLow`, `driveHigh` and `outEn` are 0 and `irqLevel` is 16'hFFFF.
- R2: Coming out of reset in continuous mode, the host drives `driveLow` from the first clock after reset release, for `startWidth`+1 consecutive clocks (`startWidth` 3..7, total low 4..8). `outEn` is 1 exactly when `driveLow` or `driveHigh` is 1.
- R3: A `startWidth` value of 0, 1 or 2 is treated as 3. `startWidth` is taken in the clock where the start pulse begins.
- R4: The last start-low clock is followed by exactly one clock of `driveHigh`, which is clock 0 of the cycle. The host then leaves the line undriven through data clocks 1 to 49.
- R5: In quiet mode, while idle, a one-clock low on `lineIn` is a start request. The host drives `driveLow` from the next clock for `startWidth` clocks, so the total low is `startWidth`+1, and then continues as in R4.
- R6: Slot N (1..16) is sampled at clock 3N-1 after clock 0. A low sample gives 0 in bit N-1 of the vector and a high sample gives 1.
- R7: `irqLevel` takes the sixteen new samples in clock 50, the first stop-low clock, and holds its value in every other clock.
- R8: After clock 49 the host drives a stop pulse and then one clock of `driveHigh`. The pulse is 3 clocks long when `modeSel[0]` is 1 in clock 49 (continuous, 01 run or 11 hold) and 2 clocks long otherwise (quiet, 00 or 10).
- R9: In continuous run mode (01), the next start pulse begins in the clock right after the stop-high clock.
- R10: After a stop in hold mode (11), the host stays idle and undriven while `modeSel` is 11. In the clock after it sees any other value, it begins its own start pulse.
- R11: Outside clock 49 and hold-idle, `modeSel` has no effect. A low on `lineIn` while idle is ignored unless the last stop selected quiet mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rstN | input | 1 | Active-low synchronous reset |
| startWidth | input | 3 | Extra start-low clocks after the first (3..7, lower values act as 3) |
| modeSel | input | 2 | Mode for the next stop pulse: 00/10 quiet, 01 continuous run, 11 continuous hold |
| lineIn | input | 1 | Resolved level of the shared line |
| driveLow | output | 1 | Host pulls the line low |
| driveHigh | output | 1 | Host drives the line high |
| outEn | output | 1 | Host drives the line at all |
| irqLevel | output | 16 | Interrupt level per slot, bit N-1 for slot N |

## Verification
Drive outputs follow the frame state with no extra register. A start request or a mode change seen at a clock edge therefore shows up on the drive pins in the very next clock. A sample taken in slot N reaches `irqLevel` only in clock 50, and the stop length is fixed by the mode value present in clock 49. The bench builds the whole expected line schedule clock by clock from these offsets. It drives each stimulus at a falling edge, queues the expected pin values for that clock, and compares them one nanosecond later. That way every check lands in the exact clock the timing rules name.

// File: rtl/serirq_pkg.sv
package serirq_pkg;
  localparam int NUM_SLOTS   = 16;
  localparam int SLOT_IDX_W  = $clog2(NUM_SLOTS);
  localparam int SLOT_CNT_W  = $clog2(NUM_SLOTS + 1);
  localparam int WIDTH_W     = 3;
  localparam int LOW_CNT_W   = WIDTH_W + 1;
  localparam int EXTRA_MIN   = 3;
  localparam int STOP_QUIET  = 2;
  localparam int STOP_CONT   = 3;

  localparam logic [1:0] MODE_QUIET = 2'b00;
  localparam logic [1:0] MODE_RUN   = 2'b01;
  localparam logic [1:0] MODE_HOLD  = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_START_HI,
    ST_DATA,
    ST_STOP_LO,
    ST_STOP_HI
  } frameState_t;

  typedef struct packed {
    logic                  sampleEn;
    logic [SLOT_IDX_W-1:0] slotIdx;
    logic                  commit;
  } dpStrobe_t;
endpackage

// File: rtl/serirq_ctrl.sv
module serirq_ctrl
  import serirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LOW_CNT_W-1:0] effWidth,
  input  logic [1:0]           modeSel,
  input  logic                 lineIn,
  output logic                 driveLow,
  output logic                 driveHigh,
  output dpStrobe_t            strobe
);
  localparam logic [SLOT_CNT_W-1:0] LAST_SLOT = SLOT_CNT_W'(NUM_SLOTS);

  frameState_t           state;
  logic [1:0]            curMode;
  logic [LOW_CNT_W-1:0]  lowCnt;
  logic [1:0]            phase;
  logic [SLOT_CNT_W-1:0] slot;
  logic                  dataDone;

  assign dataDone = (state == ST_DATA) && (slot == LAST_SLOT) && (phase == 2'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curMode <= MODE_RUN;
      lowCnt  <= '0;
      phase   <= '0;
      slot    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (curMode == MODE_RUN) begin
            state  <= ST_START;
            lowCnt <= LOW_CNT_W'(effWidth + 1'b1);
          end else if (curMode == MODE_HOLD) begin
            if (modeSel != MODE_HOLD) begin
              state  <= ST_START;
              lowCnt <= LOW_CNT_W'(effWidth + 1'b1);
            end
          end else if (!lineIn) begin
            state  <= ST_START;
            lowCnt <= effWidth;
          end
        end
        ST_START: begin
          lowCnt <= lowCnt - 1'b1;
          if (lowCnt <= LOW_CNT_W'(1)) state <= ST_START_HI;
        end
        ST_START_HI: begin
          state <= ST_DATA;
          phase <= 2'd1;
          slot  <= '0;
        end
        ST_DATA: begin
          if (dataDone) begin
            state   <= ST_STOP_LO;
            curMode <= modeSel;
            lowCnt  <= modeSel[0] ? LOW_CNT_W'(STOP_CONT) : LOW_CNT_W'(STOP_QUIET);
          end else if (phase == 2'd2) begin
            phase <= 2'd0;
            slot  <= slot + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_STOP_LO: begin
          lowCnt <= lowCnt - 1'b1;
          if (lowCnt <= LOW_CNT_W'(1)) state <= ST_STOP_HI;
        end
        ST_STOP_HI: begin
          if (curMode == MODE_RUN) begin
            state  <= ST_START;
            lowCnt <= LOW_CNT_W'(effWidth + 1'b1);
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    driveLow        = (state == ST_START) || (state == ST_STOP_LO);
    driveHigh       = (state == ST_START_HI) || (state == ST_STOP_HI);
    strobe.sampleEn = (state == ST_DATA) && (phase == 2'd2);
    strobe.slotIdx  = slot[SLOT_IDX_W-1:0];
    strobe.commit   = dataDone;
  end
endmodule

// File: rtl/serirq_datapath.sv
module serirq_datapath
  import serirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WIDTH_W-1:0]   startWidth,
  input  logic                 lineIn,
  input  dpStrobe_t            strobe,
  output logic [LOW_CNT_W-1:0] effWidth,
  output logic [NUM_SLOTS-1:0] irqLevel
);
  logic [NUM_SLOTS-1:0] shadow;

  assign effWidth = (startWidth < WIDTH_W'(EXTRA_MIN)) ? LOW_CNT_W'(EXTRA_MIN)
                                                      : LOW_CNT_W'(startWidth);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadow[i] <= 1'b1;
      end else if (strobe.sampleEn && (strobe.slotIdx == SLOT_IDX_W'(i))) begin
        shadow[i] <= lineIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqLevel <= '1;
    else if (strobe.commit) irqLevel <= shadow;
  end
endmodule

// File: rtl/serirq_host_ctrl.sv
module serirq_host_ctrl
  import serirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WIDTH_W-1:0]   startWidth,
  input  logic [1:0]           modeSel,
  input  logic                 lineIn,
  output logic                 driveLow,
  output logic                 driveHigh,
  output logic                 outEn,
  output logic [NUM_SLOTS-1:0] irqLevel
);
  dpStrobe_t            strobe;
  logic [LOW_CNT_W-1:0] effWidth;

  serirq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .effWidth  (effWidth),
    .modeSel   (modeSel),
    .lineIn    (lineIn),
    .driveLow  (driveLow),
    .driveHigh (driveHigh),
    .strobe    (strobe)
  );

  serirq_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .startWidth (startWidth),
    .lineIn     (lineIn),
    .strobe     (strobe),
    .effWidth   (effWidth),
    .irqLevel   (irqLevel)
  );

  assign outEn = driveLow | driveHigh;
endmodule

// File: rtl/serirq_host_chk.sv
module serirq_host_chk
  import serirq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 driveLow,
  input logic                 driveHigh,
  input logic                 outEn,
  input logic [NUM_SLOTS-1:0] irqLevel
);
  logic [3:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN) lowRun <= '0;
    else if (driveLow) lowRun <= (lowRun == 4'hF) ? lowRun : lowRun + 1'b1;
    else lowRun <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> (irqLevel == '1));

  // R2
  pin_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(driveLow && driveHigh) && (outEn == (driveLow || driveHigh)));

  // R4
  high_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |=> !driveHigh);

  // R4
  high_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveHigh) |-> $past(driveLow));

  // R2
  low_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |-> (lowRun < 4'd8));

  // R7
  level_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(irqLevel) |-> (driveLow && !$past(outEn)));
endmodule

bind serirq_host_ctrl serirq_host_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .driveLow  (driveLow),
  .driveHigh (driveHigh),
  .outEn     (outEn),
  .irqLevel  (irqLevel)
);

// File: tb/serirq_host_ctrl_bench.sv
module serirq_host_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  startWidth = 3'd4;
  logic [1:0]  modeSel = 2'b01;
  logic        lineIn = 1'b1;
  logic        driveLow, driveHigh, outEn;
  logic [15:0] irqLevel;

  int checks = 0;
  int fails = 0;
  logic [15:0] lvl = 16'hFFFF;
  logic        benchDone = 1'b0;

  logic        qLo[$];
  logic        qHi[$];
  logic [15:0] qLvl[$];
  string       qTag[$];

  always #2 clk = ~clk;

  serirq_host_ctrl u_serirq_host_ctrl (
    .clk(clk), .rstN(rstN), .startWidth(startWidth), .modeSel(modeSel),
    .lineIn(lineIn), .driveLow(driveLow), .driveHigh(driveHigh),
    .outEn(outEn), .irqLevel(irqLevel)
  );

  // driver: one call per clock, queues expectation and sets the line
  task automatic step(input logic lo, input logic hi, input logic line, input string tag);
    @(negedge clk);
    qLo.push_back(lo);
    qHi.push_back(hi);
    qLvl.push_back(lvl);
    qTag.push_back(tag);
    lineIn = line;
  endtask

  // monitor: compares one queued item per clock
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (qLo.size() > 0) begin
        logic        eLo, eHi;
        logic [15:0] eLvl;
        string       t;
        eLo = qLo.pop_front(); eHi = qHi.pop_front();
        eLvl = qLvl.pop_front(); t = qTag.pop_front();
        checks++;
        if (driveLow !== eLo || driveHigh !== eHi || outEn !== (eLo | eHi) || irqLevel !== eLvl) begin
          fails++;
          $display("FAIL %s t=%0t lo/hi/en/lvl act=%b/%b/%b/%h exp=%b/%b/%b/%h",
                   t, $time, driveLow, driveHigh, outEn, irqLevel, eLo, eHi, eLo | eHi, eLvl);
        end
      end
    end
  end

  // one full interrupt cycle
  task automatic runCycle(input logic slaveStart, input int ext, input logic [15:0] pat,
                          input logic [1:0] stopMode, input logic [2:0] nextW,
                          input string firstTag, input string lowTag);
    int lowLen;
    if (slaveStart) begin
      step(1'b0, 1'b0, 1'b0, firstTag);  // slave pulse
      lowLen = ext;
      for (int i = 0; i < lowLen; i++) step(1'b1, 1'b0, 1'b0, lowTag);
    end else begin
      lowLen = ext + 1;
      for (int i = 0; i < lowLen; i++) step(1'b1, 1'b0, 1'b0, (i == 0) ? firstTag : lowTag);
    end
    step(1'b0, 1'b1, 1'b1, "R4");
    for (int c = 1; c <= 49; c++) begin
      logic v;
      v = ((c % 3) == 2) ? pat[(c + 1) / 3 - 1] : 1'b1;
      step(1'b0, 1'b0, v, (c % 3 == 2) ? "R6" : "R4");
      if (c == 10) modeSel = stopMode ^ 2'b01;  // R11 mid-cycle change
      if (c == 25) startWidth = nextW;
      if (c == 30) modeSel = stopMode;
    end
    lvl = pat;  // R7 new vector in clock 50
    for (int i = 0; i < (stopMode[0] ? 3 : 2); i++) step(1'b1, 1'b0, 1'b0, (i == 0) ? "R7" : "R8");
    step(1'b0, 1'b1, 1'b1, "R8");
  endtask

  initial begin
    // R1 reset state
    step(1'b0, 1'b0, 1'b1, "R1");
    step(1'b0, 1'b0, 1'b1, "R1");
    rstN = 1'b1;
    // R2 continuous out of reset, width 4 -> low 5; stop continuous
    runCycle(1'b0, 4, 16'h5A3C, 2'b01, 3'd1, "R2", "R2");
    // R9 immediate restart; R3 width 1 acts as 3 -> low 4; stop quiet
    runCycle(1'b0, 3, 16'hC0F3, 2'b00, 3'd7, "R9", "R3");
    // R11 quiet idle: modeSel change does nothing
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, "R11");
    modeSel = 2'b01;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, "R11");
    // R5 slave start, width 7; stop hold
    runCycle(1'b1, 7, 16'h0FF0, 2'b11, 3'd3, "R5", "R5");
    // R10 hold idle, R11 line low ignored
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, "R10");
    step(1'b0, 1'b0, 1'b0, "R11");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, "R11");
    step(1'b0, 1'b0, 1'b1, "R10");
    modeSel = 2'b00;
    runCycle(1'b0, 3, 16'h9E61, 2'b00, 3'd3, "R10", "R2");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, "R8");
    @(negedge clk);
    #2;
    benchDone = 1'b1;
  end

  initial begin
    int n = 0;
    while (!benchDone && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!benchDone) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule